// File: doc/BRIEF.md
# Debug Port Serial Slave Shifter

This block is the bit-level front end of a processor debug port. An external host drives a serial clock line and a serial data-in line, and reads the slave's answer on a data-out line. Each transfer is a fixed packet of 17 bits: a status/control bit followed by a 16-bit word. Data moves both ways on every bit exchange, most significant bit first. The host gets no start-of-packet marker, so both ends count bits.

The serial clock never clocks any flop. The serial clock and data-in are passed through a two-stage synchronizer on the fast system clock. A rising level of the synchronized serial clock, seen after it was low, acts as a one-cycle shift enable. The shift state advances on the third system clock edge after the serial clock is first sampled high. Data-out follows on the fourth edge. Each received packet goes to a command decoder with a one-cycle strobe. The decoder supplies the response packet, which is taken in at packet boundaries.

Top module: `dbg_serial_slave`

## Requirements
- R1: While `rst_n` is low, `sdo_o` is 0, `rx_valid_o` is 0 and `rx_pkt_o` is 0, and the bit counter is at 0. The reset is asserted asynchronously and released synchronously.
- R2: A received packet holds the first bit shifted in at bit 16 of `rx_pkt_o` and the last bit shifted in at bit 0.
- R3: On the 17th bit exchange, `rx_valid_o` is high for exactly one system clock cycle. It rises at the third rising system clock edge counted from the first edge that samples `sclk_i` high, and `rx_pkt_o` holds the packet from then on.
- R4: Before exchange k (k = 0..16) of a packet, `sdo_o` shows bit 16-k of the response packet. After each exchange it moves to the next bit on the fourth rising edge counted from the first edge that samples `sclk_i` high.
- R5: A serial clock that is held high for any number of system cycles advances the packet by exactly one bit. The synchronized clock must be seen low before the next bit is taken.
- R6: After the 17th bit the counter returns to 0, so packets may follow each other back to back. A reset in the middle of a packet restarts the count from bit 0.
- R7: `tx_pkt_i` is taken in only while the counter is at 0 or at the 17th exchange. Changes to it during bits 1..16 do not alter the bits on `sdo_o` for that packet.
- R8: Transfers work at every serial clock rate up to one fifth of the system clock, with high or low phases as short as one system cycle.
- R9: With no transfer in progress (counter at 0), `sdo_o` shows bit 16 of `tx_pkt_i` within two system cycles of a change to `tx_pkt_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data from the host, asynchronous |
| tx_pkt_i | input | 17 | Response packet to send, status bit at bit 16 |
| sdo_o | output | 1 | Serial data to the host, registered |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received packet |
| rx_pkt_o | output | 17 | Last received packet, status bit at bit 16 |

## Verification
The hardest situation to reach from the ports is a serial clock that stays high far longer than one bit. A design that re-arms on level instead of on the low phase would slip extra bits without any visible error at that moment. The stimulus holds the clock high for 30 cycles on a chosen bit in the middle of a packet. It then checks every later data-out bit and the final received word, so any extra shift shows up as a misaligned packet. A mid-packet reset and a cycle-exact walk through the last bit of a packet cover the counter restart and the third-edge and fourth-edge timing. Random high and low phase lengths down to a single cycle cover the rate limit.

// File: rtl/dbgs_pkg.sv
package dbgs_pkg;
  // one sample of the two asynchronous host lines, kept together so both
  // pass through the same number of synchronizer stages
  typedef struct packed {
    logic sclk;
    logic sdi;
  } dbgs_line_t;
endpackage

// File: rtl/dbgs_sync.sv
module dbgs_sync
  import dbgs_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dbgs_line_t line_i,
  output dbgs_line_t line_o
);
  dbgs_line_t [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= line_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/dbgs_edge.sv
module dbgs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s_i,
  output logic step_o
);
  logic armed_q, armed_d;

  // a step needs the clock high after a low phase has re-armed the detector
  always_comb begin
    step_o  = sclk_s_i & armed_q;
    armed_d = armed_q;
    if (!sclk_s_i) begin
      armed_d = 1'b1;
    end else if (step_o) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/dbgs_shift.sv
module dbgs_shift #(
  parameter int PKT_W = 17,
  parameter int CNT_W = $clog2(PKT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             din_i,
  input  logic [PKT_W-1:0] tx_pkt_i,
  output logic             tx_msb_o,
  output logic             rx_valid_o,
  output logic [PKT_W-1:0] rx_pkt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PKT_W-2:0] rx_sh_q, rx_sh_d;
  logic [PKT_W-1:0] tx_sh_q, tx_sh_d;
  logic [PKT_W-1:0] rx_pkt_q, rx_pkt_d;
  logic             rx_valid_q, rx_valid_d;
  logic             last_bit;

  assign last_bit = (cnt_q == LAST);

  always_comb begin
    cnt_d      = cnt_q;
    rx_sh_d    = rx_sh_q;
    tx_sh_d    = tx_sh_q;
    rx_pkt_d   = rx_pkt_q;
    rx_valid_d = 1'b0;
    if (step_i) begin
      rx_sh_d = {rx_sh_q[PKT_W-3:0], din_i};
      if (last_bit) begin
        cnt_d      = '0;
        rx_valid_d = 1'b1;
        rx_pkt_d   = {rx_sh_q, din_i};
        tx_sh_d    = tx_pkt_i;
      end else begin
        cnt_d   = cnt_q + 1'b1;
        tx_sh_d = {tx_sh_q[PKT_W-2:0], 1'b0};
      end
    end else if (cnt_q == '0) begin
      // idle between packets: keep the pending response loaded
      tx_sh_d = tx_pkt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rx_pkt_q   <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      rx_sh_q    <= rx_sh_d;
      tx_sh_q    <= tx_sh_d;
      rx_pkt_q   <= rx_pkt_d;
      rx_valid_q <= rx_valid_d;
    end
  end

  assign tx_msb_o   = tx_sh_q[PKT_W-1];
  assign rx_valid_o = rx_valid_q;
  assign rx_pkt_o   = rx_pkt_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/dbg_serial_slave.sv
module dbg_serial_slave
  import dbgs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PKT_W       = DATA_W + 1,
  parameter int CNT_W       = $clog2(PKT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic [PKT_W-1:0] tx_pkt_i,
  output logic             sdo_o,
  output logic             rx_valid_o,
  output logic [PKT_W-1:0] rx_pkt_o
);
  dbgs_line_t       raw_w, sync_w;
  logic             sclk_s_w, step_w, tx_msb_w;
  logic [CNT_W-1:0] cnt_w;
  logic             sdo_q, sdo_d;

  assign raw_w.sclk = sclk_i;
  assign raw_w.sdi  = sdi_i;
  assign sclk_s_w   = sync_w.sclk;

  dbgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (raw_w),
    .line_o (sync_w)
  );

  dbgs_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s_i (sclk_s_w),
    .step_o   (step_w)
  );

  dbgs_shift #(.PKT_W(PKT_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_w),
    .din_i      (sync_w.sdi),
    .tx_pkt_i   (tx_pkt_i),
    .tx_msb_o   (tx_msb_w),
    .rx_valid_o (rx_valid_o),
    .rx_pkt_o   (rx_pkt_o),
    .cnt_o      (cnt_w)
  );

  // output register: data-out lags the shift state by one cycle
  assign sdo_d = tx_msb_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else begin
      sdo_q <= sdo_d;
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/dbgs_chk.sv
module dbgs_chk #(
  parameter int PKT_W = 17,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic             rx_valid,
  input logic             sdo
);
  // R1: reset holds outputs and counter quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!sdo && !rx_valid && cnt == '0));

  // R6: counter never passes the last bit position
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= PKT_W - 1);

  // R5: one step per high phase, never two in a row
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  // R5: the count moves only on a step
  assert_count_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));

  // R3: strobe follows a step that wrapped the counter, and lasts one cycle
  assert_valid_after_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cnt == '0 && $past(step)));
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: data-out moves only two cycles after a step or an idle reload
  assert_sdo_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(step, 2) || $past(cnt, 2) == '0));
endmodule

bind dbg_serial_slave dbgs_chk #(.PKT_W(PKT_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step_w),
  .cnt      (cnt_w),
  .rx_valid (rx_valid_o),
  .sdo      (sdo_o)
);

// File: tb/sim_dbg_serial_slave.sv
module sim_dbg_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sclk, sdi;
  logic [PW-1:0] tx_pkt;
  logic          sdo, rx_valid;
  logic [PW-1:0] rx_pkt;

  int            total = 0;
  int            bad = 0;
  int            vcount = 0;
  logic [PW-1:0] vlast = '0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_serial_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (sclk),
    .sdi_i      (sdi),
    .tx_pkt_i   (tx_pkt),
    .sdo_o      (sdo),
    .rx_valid_o (rx_valid),
    .rx_pkt_o   (rx_pkt)
  );

  always @(negedge clk) begin
    if (rx_valid === 1'b1) begin
      vcount++;
      vlast = rx_pkt;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [PW-1:0] p, input int k);
    return p[PW-1-k];
  endfunction

  // entered and left at a falling system clock edge
  task automatic bit_xfer(input logic d, input int hi, input int lo);
    sdi  = d;
    sclk = 1'b1;
    repeat (hi) @(negedge clk);
    sclk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [PW-1:0] rxv, input logic [PW-1:0] txv,
                          input int hi_f, input int lo_f, input int long_bit,
                          input bit scramble);
    int v0;
    @(negedge clk);
    tx_pkt = txv;
    repeat (3) @(negedge clk);
    check("R9 idle msb", 32'(sdo), 32'(exp_bit(txv, 0)));
    v0 = vcount;
    for (int k = 0; k < PW; k++) begin
      int hi, lo;
      check(scramble ? "R7 sdo with tx changing" : "R4 sdo bit", 32'(sdo), 32'(exp_bit(txv, k)));
      hi = (hi_f > 0) ? hi_f : 1 + int'($urandom_range(0, 3));
      lo = (lo_f > 0) ? lo_f : 1 + int'($urandom_range(0, 3));
      if (hi + lo < 4) lo = 4 - hi;
      if (k == long_bit) hi = 30;
      if (scramble && k > 0 && k < PW - 1) tx_pkt = PW'($urandom);
      bit_xfer(rxv[PW-1-k], hi, lo);
      if (k == long_bit)
        check("R5 no strobe after long high", 32'(vcount), 32'(v0 + ((k == PW - 1) ? 1 : 0)));
    end
    #1;
    check("R3 one strobe per packet", 32'(vcount), 32'(v0 + 1));
    check("R2 received packet", 32'(vlast), 32'(rxv));
  endtask

  // cycle-exact walk through the last bit of a packet
  task automatic timing_pkt(input logic [PW-1:0] rxv, input logic [PW-1:0] txv);
    @(negedge clk);
    tx_pkt = txv;
    repeat (3) @(negedge clk);
    for (int k = 0; k < PW - 1; k++) bit_xfer(rxv[PW-1-k], 2, 2);
    check("R4 last bit on sdo", 32'(sdo), 32'(txv[0]));
    sdi  = rxv[0];
    sclk = 1'b1;
    @(posedge clk); #1;
    check("R3 no strobe at edge 1", 32'(rx_valid), 32'd0);
    @(posedge clk); #1;
    check("R3 no strobe at edge 2", 32'(rx_valid), 32'd0);
    @(posedge clk); #1;
    check("R3 strobe at edge 3", 32'(rx_valid), 32'd1);
    check("R3 packet at edge 3", 32'(rx_pkt), 32'(rxv));
    check("R4 sdo unchanged at edge 3", 32'(sdo), 32'(txv[0]));
    @(posedge clk); #1;
    check("R3 strobe gone at edge 4", 32'(rx_valid), 32'd0);
    check("R4 sdo moves at edge 4", 32'(sdo), 32'(txv[PW-1]));
    @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n  = 1'b0;
    sclk   = 1'b0;
    sdi    = 1'b0;
    tx_pkt = '1;
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", 32'(sdo), 32'd0);
    check("R1 strobe in reset", 32'(rx_valid), 32'd0);
    check("R1 packet in reset", 32'(rx_pkt), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: idle output tracks the pending response MSB
    tx_pkt = 17'h0_0000;
    repeat (2) @(negedge clk);
    check("R9 idle msb low", 32'(sdo), 32'd0);
    tx_pkt = 17'h1_0000;
    repeat (2) @(negedge clk);
    check("R9 idle msb high", 32'(sdo), 32'd1);

    // R2/R4 directed patterns
    send_pkt(17'h1_A5C3, 17'h0_F00F, 2, 2, -1, 1'b0);
    send_pkt(17'h0_0001, 17'h1_FFFE, 2, 3, -1, 1'b0);
    // R8: fastest rate, both phase shapes
    send_pkt(17'h1_2345, 17'h0_5AA5, 1, 4, -1, 1'b0);
    send_pkt(17'h0_CAFE, 17'h1_3C3C, 4, 1, -1, 1'b0);
    // R5: long high phases mid packet and on the last bit
    send_pkt(17'h1_0F0F, 17'h1_7E81, 2, 2, 5, 1'b0);
    send_pkt(17'h0_8421, 17'h0_1248, 2, 2, 16, 1'b0);
    // R7: response changes mid packet
    send_pkt(17'h1_BEEF, 17'h1_6699, 0, 0, -1, 1'b1);
    // R3/R4 exact edges
    timing_pkt(17'h1_5555, 17'h1_2AAA);

    // R6: reset mid packet restarts the count
    @(negedge clk);
    tx_pkt = 17'h1_FFFF;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 7; k++) bit_xfer(1'b1, 2, 2);
    rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 sdo after mid reset", 32'(sdo), 32'd0);
    check("R1 packet after mid reset", 32'(rx_pkt), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_pkt(17'h0_7531, 17'h1_1357, 2, 2, -1, 1'b0);

    // R6: back-to-back random packets at random rates
    for (int p = 0; p < 30; p++) begin
      send_pkt(PW'($urandom), PW'($urandom), 0, 0,
               (p % 7 == 3) ? int'($urandom_range(0, 16)) : -1, (p % 5 == 2));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule